// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block turns a CPU address in the upper part of a 16-bit address space into a program-ROM address. The address is split into a bank number and an offset within the bank. Software programs the translation through a small register write port. Four bank registers hold the inner bank numbers. A main control byte picks the window layout. An outer control byte supplies two high bank bits that sit above every inner bank number.

The mapper supports two window sizes. It can use two 16 KB windows or four 8 KB windows. One 8 KB variant fixes the top window to the last inner bank. That variant can also expose bank register 3 in the 0x6000–0x7FFF window. A valid flag tells the system when a read in that low window is served from ROM.

The translation is combinational from the CPU address and the stored registers. Register writes are captured on the clock edge. ROM storage and CPU bus timing are outside the block.

Top module: `pbm_mapper`

## Requirements
- R1: After reset, all four bank registers and both control bytes hold 0xFF. So any address at 0x8000 or above maps to 8 KB bank 0xFF, with `rom_addr = {8'hFF, cpu_addr[12:0]}`, and `win6_valid` is low.
- R2: A write is decoded from `wr_addr & 16'hF007`.
  - Masked values 0x8000–0x8003 write bank register `masked[1:0]`.
  - Masked values with upper nibble 0xD write the main control byte when `masked[1:0]` = 0, and the outer control byte when `masked[1:0]` = 3.
  - Every other masked value, for example 0x8004 or 0xD001, changes nothing.
- R3: When main control bits 1:0 equal 1 (16 KB mode), `rom_addr = {outer[2:1], reg[4:0], cpu_addr[13:0]}`. Here `reg` is bank register 0 for 0x8000–0xBFFF and bank register 2 for 0xC000–0xFFFF.
- R4: When main control bits 1:0 equal 0 or 3, the window index is `cpu_addr[14:13]` for addresses at 0x8000 and above. In that case `rom_addr = {outer[2:1], reg[index][5:0], cpu_addr[12:0]}`.
- R5: When main control bits 1:0 equal 2 and main bit 2 is set, the mapping is identical to R4.
- R6: When main control bits 1:0 equal 2 and main bit 2 is clear, the 0xE000–0xFFFF window uses inner bank 0x3F. The other three windows follow R4.
- R7: When main control bits 1:0 equal 2, main bit 2 is clear and main bit 7 is set, a read in 0x6000–0x7FFF raises `win6_valid`. That read maps to `{outer[2:1], reg3[5:0], cpu_addr[12:0]}`.
- R8: For every other 0x6000–0x7FFF case, and for every address below 0x6000, `win6_valid` is low and `rom_addr` is 0.
- R9: A write changes the translation starting with the cycle after the clock edge that captures it. Without writes, a stable CPU address gives a stable `rom_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register capture |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 21 | Translated program-ROM byte address |
| win6_valid | output | 1 | High when the 0x6000–0x7FFF window is mapped to ROM |

## Verification
The bench builds the mapper with its default parameters: 6-bit inner 8 KB banks, 5-bit inner 16 KB banks, a 2-bit outer field and a 21-bit ROM address. With these values, random register data reaches every outer bank value and every inner bank value. Random control bytes cover all four layouts, together with both settings of the fixed-window bit and the low-window enable bit. Write addresses carry random filler in the bits the decode mask clears. This exercises aliasing as well as addresses that must be ignored.

// File: rtl/pbm_pkg.sv
// Package: shared layout codes and decode constants for the program bank mapper.
// Assumes a 16-bit CPU address space with 8 KB page granularity.
package pbm_pkg;
    typedef enum logic [1:0] {
        MODE_8K_A   = 2'd0,
        MODE_16K    = 2'd1,
        MODE_8K_FIX = 2'd2,
        MODE_8K_B   = 2'd3
    } prg_mode_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_LOW  = 2'd1,
        RGN_ROM  = 2'd2
    } region_e;

    localparam logic [15:0] DEC_MASK   = 16'hF007;
    localparam logic [3:0]  BANK_PAGE  = 4'h8;
    localparam logic [3:0]  CTRL_PAGE  = 4'hD;
    localparam int          FIX_BIT    = 2;
    localparam int          LOWWIN_BIT = 7;
endpackage

// File: rtl/pbm_regfile.sv
// Module: register file of the mapper. It decodes writes through a fixed address
// mask and holds four bank registers plus the main and outer control bytes.
// Assumes: synchronous active-low reset that loads all ones into every register.
module pbm_regfile
    import pbm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bank_q [NUM_BANKS],
    output logic [DATA_W-1:0] ctl_main,
    output logic [DATA_W-1:0] ctl_outer
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    logic [15:0] masked;
    logic        ctl_page_hit;

    // Apply the decode mask and flag the control page.
    always_comb begin
        masked       = wr_addr & DEC_MASK;
        ctl_page_hit = wr_en && (masked[15:12] == CTRL_PAGE);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
            logic hit;
            // Match one exact masked address in the bank page.
            assign hit = wr_en && (masked == {BANK_PAGE, 12'(gi)});
            // Store one bank register.
            always_ff @(posedge clk) begin
                if (!rst_n)   bank_q[gi] <= '1;
                else if (hit) bank_q[gi] <= wr_data;
            end
        end
    endgenerate

    // Store the main and outer control bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_main  <= '1;
            ctl_outer <= '1;
        end else if (ctl_page_hit) begin
            if (masked[1:0] == 2'd0) ctl_main  <= wr_data;
            if (masked[1:0] == 2'd3) ctl_outer <= wr_data;
        end
    end

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/pbm_window_decode.sv
// Module: classifies a CPU address as below the mapped range, in the low
// 0x6000-0x7FFF window, or in ROM space, and extracts the 8 KB window index.
// Assumes: page size is 2**PAGE_W bytes and the address is 16 bits.
module pbm_window_decode
    import pbm_pkg::*;
#(
    parameter int PAGE_W = 13
) (
    input  logic [15:0] cpu_addr,
    output region_e     region,
    output logic [1:0]  win_idx
);
    // Pick the region from the top address bits and the window from the next two.
    always_comb begin
        win_idx = cpu_addr[PAGE_W+1:PAGE_W];
        if (cpu_addr[15])                       region = RGN_ROM;
        else if (cpu_addr[15:PAGE_W] == 3'b011) region = RGN_LOW;
        else                                    region = RGN_NONE;
    end
endmodule

// File: rtl/pbm_bank_select.sv
// Module: forms the program-ROM address from the region, the window index, the
// bank registers and the control bytes. It covers the 16 KB mode, the plain
// 8 KB modes and the 8 KB mode with a fixed last window.
// Assumes: INNER16_W equals INNER8_W - 1, so both window sizes fill ROM_AW bits.
module pbm_bank_select
    import pbm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4,
    parameter int PAGE_W    = 13,
    parameter int INNER8_W  = 6,
    parameter int OUTER_W   = 2,
    parameter int OUTER_LSB = 1,
    localparam int INNER16_W = INNER8_W - 1,
    localparam int ROM_AW    = PAGE_W + INNER8_W + OUTER_W
) (
    input  logic [15:0]       cpu_addr,
    input  region_e           region,
    input  logic [1:0]        win_idx,
    input  logic [DATA_W-1:0] bank_q [NUM_BANKS],
    input  logic [DATA_W-1:0] ctl_main,
    input  logic [DATA_W-1:0] ctl_outer,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              win6_valid
);
    prg_mode_e            mode;
    logic [OUTER_W-1:0]   outer;
    logic                 fix_last;
    logic [INNER8_W-1:0]  inner8;
    logic [INNER16_W-1:0] inner16;

    // Decode the layout and the fixed-window condition from the control bytes.
    always_comb begin
        mode     = prg_mode_e'(ctl_main[1:0]);
        outer    = ctl_outer[OUTER_LSB +: OUTER_W];
        fix_last = (mode == MODE_8K_FIX) && !ctl_main[FIX_BIT];
    end

    // Choose the inner bank for the current window.
    always_comb begin
        inner16 = cpu_addr[PAGE_W+1] ? bank_q[2][INNER16_W-1:0] : bank_q[0][INNER16_W-1:0];
        if (region == RGN_LOW)               inner8 = bank_q[3][INNER8_W-1:0];
        else if (fix_last && win_idx == 2'd3) inner8 = '1;
        else                                  inner8 = bank_q[win_idx][INNER8_W-1:0];
    end

    // Assemble the ROM address and the low-window valid flag.
    always_comb begin
        rom_addr   = '0;
        win6_valid = 1'b0;
        if (region == RGN_ROM) begin
            if (mode == MODE_16K) rom_addr = {outer, inner16, cpu_addr[PAGE_W:0]};
            else                  rom_addr = {outer, inner8, cpu_addr[PAGE_W-1:0]};
        end else if (region == RGN_LOW && fix_last && ctl_main[LOWWIN_BIT]) begin
            win6_valid = 1'b1;
            rom_addr   = {outer, inner8, cpu_addr[PAGE_W-1:0]};
        end
    end
endmodule

// File: rtl/pbm_mapper.sv
// Module: top of the program bank mapper. It joins the register file, the address
// region decoder and the bank selector. Translation is combinational, and
// register writes take effect after the capturing clock edge.
// Assumes: synchronous active-low reset; 16-bit CPU addresses.
module pbm_mapper
    import pbm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4,
    parameter int PAGE_W    = 13,
    parameter int INNER8_W  = 6,
    parameter int OUTER_W   = 2,
    parameter int OUTER_LSB = 1,
    localparam int ROM_AW   = PAGE_W + INNER8_W + OUTER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [15:0]       cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              win6_valid
);
    logic [DATA_W-1:0] bank_q [NUM_BANKS];
    logic [DATA_W-1:0] ctl_main;
    logic [DATA_W-1:0] ctl_outer;
    region_e           region;
    logic [1:0]        win_idx;

    pbm_regfile #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_q(bank_q), .ctl_main(ctl_main),
        .ctl_outer(ctl_outer)
    );

    pbm_window_decode #(.PAGE_W(PAGE_W)) u_dec (
        .cpu_addr(cpu_addr), .region(region), .win_idx(win_idx)
    );

    pbm_bank_select #(
        .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .PAGE_W(PAGE_W),
        .INNER8_W(INNER8_W), .OUTER_W(OUTER_W), .OUTER_LSB(OUTER_LSB)
    ) u_sel (
        .cpu_addr(cpu_addr), .region(region), .win_idx(win_idx),
        .bank_q(bank_q), .ctl_main(ctl_main), .ctl_outer(ctl_outer),
        .rom_addr(rom_addr), .win6_valid(win6_valid)
    );
endmodule

// File: rtl/pbm_mapper_chk.sv
// Module: assertion checker for the program bank mapper, bound to the top.
// Assumes: default parameter layout, where the page offset is 13 bits and
// the outer field occupies the top two ROM address bits.
module pbm_mapper_chk #(
    parameter int DATA_W = 8,
    parameter int ROM_AW = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       cpu_addr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              win6_valid,
    input logic [DATA_W-1:0] ctl_main,
    input logic [DATA_W-1:0] ctl_outer
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && cpu_addr[15]) |-> (rom_addr[ROM_AW-1:13] == '1 && !win6_valid));

    // R8
    low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!win6_valid && rom_addr == '0));

    // R7
    valid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win6_valid |-> (cpu_addr[15:13] == 3'b011 && ctl_main[1:0] == 2'd2));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> (rom_addr[12:0] == cpu_addr[12:0]));

    // R3
    outer_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> (rom_addr[ROM_AW-1:ROM_AW-2] == ctl_outer[2:1]));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(cpu_addr)) |-> $stable(rom_addr));
endmodule

bind pbm_mapper pbm_mapper_chk #(.DATA_W(DATA_W), .ROM_AW(ROM_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpu_addr(cpu_addr),
    .rom_addr(rom_addr), .win6_valid(win6_valid), .ctl_main(ctl_main),
    .ctl_outer(ctl_outer)
);

// File: tb/pbm_mapper_tb.sv
module pbm_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [20:0] rom_addr;
    logic        win6_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_bank [4];
    logic [7:0] m_main;
    logic [7:0] m_outer;

    always #10 clk = ~clk;

    pbm_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .rom_addr(rom_addr),
        .win6_valid(win6_valid)
    );

    // Reference model: expected ROM address, taken from the requirements.
    function automatic logic [21:0] expect_map(input logic [15:0] a);
        logic [1:0] md;
        logic [1:0] ob;
        logic       fix;
        logic [5:0] inr;
        md  = m_main[1:0];
        ob  = m_outer[2:1];
        fix = (md == 2'd2) && !m_main[2];
        if (a[15]) begin
            if (md == 2'd1) begin
                inr = {1'b0, (a[14] ? m_bank[2][4:0] : m_bank[0][4:0])};
                return {1'b0, ob, inr[4:0], a[13:0]};
            end
            inr = (fix && a[14:13] == 2'd3) ? 6'h3F : m_bank[a[14:13]][5:0];
            return {1'b0, ob, inr, a[12:0]};
        end
        if (a[15:13] == 3'b011 && fix && m_main[7])
            return {1'b1, ob, m_bank[3][5:0], a[12:0]};
        return '0;
    endfunction

    // Update the model as the requirements describe for a write.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] m;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m = a & 16'hF007;
        if (m[15:2] == 14'h2000) m_bank[m[1:0]] = d;
        else if (m[15:12] == 4'hD && m[1:0] == 2'd0) m_main = d;
        else if (m[15:12] == 4'hD && m[1:0] == 2'd3) m_outer = d;
    endtask

    task automatic check_addr(input logic [15:0] a, input string req);
        logic [21:0] e;
        cpu_addr = a;
        #2;
        e = expect_map(a);
        n_checks++;
        if (rom_addr !== e[20:0] || win6_valid !== e[21]) begin
            n_fails++;
            $display("FAIL %s addr=%h actual rom=%h valid=%b expected rom=%h valid=%b",
                     req, a, rom_addr, win6_valid, e[20:0], e[21]);
        end
    endtask

    task automatic sweep(input string req);
        for (int w = 0; w < 8; w++) check_addr(16'(w * 16'h2000) + 16'h0123, req);
    endtask

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 4; i++) m_bank[i] = 8'hFF;
        m_main = 8'hFF; m_outer = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_addr(16'h8000, "R1"); check_addr(16'hFFFF, "R1"); check_addr(16'h6010, "R1");
        // R2 bank and control writes, aliases, ignored addresses
        do_write(16'h8000, 8'h05); do_write(16'h8FF1, 8'h11);
        do_write(16'h8002, 8'h22); do_write(16'h8003, 8'h33);
        do_write(16'hD000, 8'h00); do_write(16'hD003, 8'h02);
        sweep("R2");
        do_write(16'h8004, 8'h3C); do_write(16'hD001, 8'h01); do_write(16'hD002, 8'h02);
        do_write(16'h9000, 8'h07);
        sweep("R2");
        // R4 mode 3
        do_write(16'hD000, 8'h03); sweep("R4");
        // R3 16 KB mode, outer = 3
        do_write(16'hD7F8, 8'h01); do_write(16'hD003, 8'h06); sweep("R3");
        // R5 mode 2 with bit 2 set
        do_write(16'hD000, 8'h86); sweep("R5");
        // R6 fixed last window, no low window
        do_write(16'hD000, 8'h02); sweep("R6");
        check_addr(16'hFFFF, "R6"); check_addr(16'h7FFF, "R8");
        // R7 low window enabled
        do_write(16'hD000, 8'h82); check_addr(16'h6000, "R7"); check_addr(16'h7ABC, "R7");
        check_addr(16'h5FFF, "R8"); check_addr(16'h0000, "R8");
        // R9 write visible on the next cycle
        cpu_addr = 16'h8123;
        @(negedge clk); wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h2A;
        #2; n_checks++;
        if (rom_addr !== expect_map(16'h8123)) begin
            n_fails++; $display("FAIL R9 early change actual=%h expected=%h", rom_addr, expect_map(16'h8123));
        end
        @(negedge clk); wr_en = 1'b0; m_bank[0] = 8'h2A;
        check_addr(16'h8123, "R9");
        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [15:0] wa;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 7));
            wa = {4'h0, 9'($urandom), 3'($urandom)};
            case (pick)
                3'd0, 3'd1, 3'd2: wa[15:12] = 4'h8;
                3'd3, 3'd4:       wa[15:12] = 4'hD;
                default:          wa[15:12] = 4'($urandom);
            endcase
            do_write(wa, 8'($urandom));
            for (int k = 0; k < 3; k++) check_addr(16'($urandom), "R4");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule